// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire Block Access)

This block is the configuration port of a system clock generator. It sits on a two-wire serial bus (I2C/SMBus electrical style) as a slave at the fixed 7-bit address 1101001. It keeps seven 8-bit configuration bytes and drives their bits straight into the generator's output gating logic: output enables, stop masks, frequency and spread selections, and edge-rate codes.

Registers are not addressed by index. A write transfer carries two filler bytes, which the slave acknowledges and throws away, and then the configuration bytes from byte 0 upward. A read transfer returns a byte-count value of 8 and then the configuration bytes from byte 0 upward. Some bits are read-only. They return the frequency-select and current-multiplier straps, which are captured once after reset, the live level of the CPU-stop pin, and a fixed identification byte.

Both bus lines are sampled by the system clock. Each line passes through a two-stage synchronizer and a stability filter before the slave looks for START, STOP and clock edges. The slave never stretches the clock, does not arbitrate and does not answer general calls. The serial bus is the block's only data path, so the block has no valid/ready interface. All other pins are plain levels.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: Only an address byte whose upper seven bits are 1101001 is acknowledged. The R/W bit is bit 0 of that byte, with 0 meaning write and 1 meaning read. A transfer to any other address gets no acknowledge and changes no configuration output.
- R2: In a write, the slave acknowledges every byte. The first two bytes after the address are ignored. The following bytes land in configuration bytes 0, 1, 2, … in that order. Bytes past byte 6 are acknowledged and discarded.
- R3: A read returns 0x08 first and then configuration bytes 0 to 6. Any byte past byte 6 reads 0x00. A master NACK ends the slave's transmission.
- R4: After reset, every output enable is 1. This covers the CPU enables, the PCI enables, the free-running PCI enables, the USB and DOT enables and the six 66 MHz enables. The PCI-stop control (byte 0 bit 3) is 1. The 48 MHz select, spread enable, all stop masks and both edge-rate fields are 0.
- R5: Byte 0 bits 2:0 read the select straps S0, S1 and S2, captured on the first clock after reset. Bit 4 reads the current CPU-stop pin. Bit 3 is the writable PCI-stop control. Bit 5 is the writable 48 MHz select (0 selects 66 MHz). Bit 7 is the writable spread enable.
- R6: Byte 1 bits 2:0 are the three CPU pair enables. Bits 5:3 are the per-pair CPU-stop controls. Bit 7 reads the captured multiplier strap.
- R7: Byte 2 bits 6:0 are the PCI0–PCI6 enables. Byte 3 bits 2:0 are the free-running PCI enables, bits 5:3 their stop masks, bit 6 the USB enable and bit 7 the DOT enable. Byte 4 bits 5:0 are the six 66 MHz enables.
- R8: Byte 5 bits 1:0 are the USB edge-rate code and bits 3:2 the DOT edge-rate code. Byte 6 always reads 0x07, which is a vendor ID of 0111 in bits 3:0 and a revision of 0000 in bits 7:4.
- R9: Read-only and unused bits ignore writes. Unused bits read 0. A write to byte 6 changes nothing.
- R10: A write that ends with a STOP keeps every byte completed before the STOP. A byte cut off partway is not stored.
- R11: A pulse on SCL or SDA lasting fewer than FILT_LEN system clocks is ignored. It neither shifts a bit nor forms a START or STOP.
- R12: The slave changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_fs_i | input | 3 | Frequency-select straps S2..S0 |
| strap_mult_i | input | 1 | Current-multiplier strap |
| cpu_stop_pin_i | input | 1 | CPU-stop pin level |
| pci_stop_ctl_o | output | 1 | Byte 0 bit 3 |
| vch_48m_sel_o | output | 1 | 1 selects 48 MHz on the shared output |
| spread_en_o | output | 1 | Spread-spectrum enable |
| cpu_en_o | output | 3 | CPU pair enables |
| cpu_stop_ctl_o | output | 3 | Per-pair CPU-stop controls |
| pci_en_o | output | 7 | PCI output enables |
| pcif_en_o | output | 3 | Free-running PCI enables |
| pcif_stop_ctl_o | output | 3 | Free-running PCI stop masks |
| usb_en_o | output | 1 | USB 48 MHz enable |
| dot_en_o | output | 1 | DOT 48 MHz enable |
| clk66_en_o | output | 6 | 66 MHz output enables |
| usb_edge_o | output | 2 | USB edge-rate code |
| dot_edge_o | output | 2 | DOT edge-rate code |

## Verification
Two situations are hard to reach from the ports. The first is a write cut short by STOP, either right after a complete byte or in the middle of one. The bench shifts four bits of a data byte, issues STOP from the low clock phase, and then reads every configuration output to confirm that completed bytes stuck and the partial one did not. The second is noise on the lines: single-cycle pulses are placed on SCL while it is low and on SDA while SCL is high, where an unfiltered slave would see an extra bit or a false START. The data written through them must still land intact.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned NBYTES      = 7;
  localparam int unsigned DUMMY_BYTES = 2;
  localparam logic [7:0]  COUNT_BYTE  = 8'h08;
  localparam logic [7:0]  ID_BYTE     = 8'h07;
  localparam int unsigned IDX_W       = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } bus_st_e;

  // writable bits of each configuration byte
  function automatic logic [7:0] byte_wmask(int unsigned i);
    case (i)
      0: return 8'hA8;
      1: return 8'h3F;
      2: return 8'h7F;
      3: return 8'hFF;
      4: return 8'h3F;
      5: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] byte_rstval(int unsigned i);
    case (i)
      0: return 8'h08;
      1: return 8'h07;
      2: return 8'h7F;
      3: return 8'hC7;
      4: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_deglitch.sv
module clkcfg_deglitch #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clean_o = clean_q;

  // R11
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q != $past(clean_q)) |-> ($past(sync_q[1]) == clean_q));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [7:0]           rd_data_o,
  input  logic [2:0]           strap_fs_i,
  input  logic                 strap_mult_i,
  input  logic                 cpu_stop_pin_i,
  output logic [NBYTES*8-1:0]  cfg_o
);
  logic [2:0] fs_q;
  logic       mult_q;
  logic       taken_q;
  logic [1:0] stop_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q        <= '0;
      mult_q      <= 1'b0;
      taken_q     <= 1'b0;
      stop_sync_q <= '0;
    end else begin
      stop_sync_q <= {stop_sync_q[0], cpu_stop_pin_i};
      if (!taken_q) begin
        fs_q    <= strap_fs_i;
        mult_q  <= strap_mult_i;
        taken_q <= 1'b1;
      end
    end
  end

  logic [7:0] rd_byte [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [7:0] WM = byte_wmask(g);
    localparam logic [7:0] RV = byte_rstval(g);
    logic [7:0] store_q;
    logic [7:0] ro_bits;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store_q <= RV & WM;
      else if (wr_en_i && wr_idx_i == 3'(g))
        store_q <= wr_data_i & WM;
    end

    if (g == 0) begin : g_ro0
      assign ro_bits = {3'b000, stop_sync_q[1], 1'b0, fs_q};
    end else if (g == 1) begin : g_ro1
      assign ro_bits = {mult_q, 7'b0};
    end else if (g == NBYTES - 1) begin : g_ro6
      assign ro_bits = ID_BYTE;
    end else begin : g_rox
      assign ro_bits = 8'h00;
    end

    assign rd_byte[g]       = store_q | ro_bits;
    assign cfg_o[g*8 +: 8]  = store_q;
  end

  always_comb begin
    if (rd_idx_i == '0)
      rd_data_o = COUNT_BYTE;
    else if (rd_idx_i <= IDX_W'(NBYTES))
      rd_data_o = rd_byte[3'(rd_idx_i - 1'b1)];
    else
      rd_data_o = 8'h00;
  end

  // R9
  ro_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 3'(NBYTES - 1)) |=> (cfg_o == $past(cfg_o)));
endmodule

// File: rtl/clkcfg_busctl.sv
module clkcfg_busctl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f_i,
  input  logic             sda_f_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [2:0]       wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_data_i
);
  logic scl_d, sda_d;
  logic start_ev, stop_ev, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f_i;
      sda_d <= sda_f_i;
    end
  end

  assign start_ev = scl_f_i & scl_d & sda_d & ~sda_f_i;
  assign stop_ev  = scl_f_i & scl_d & ~sda_d & sda_f_i;
  assign scl_rise = scl_f_i & ~scl_d;
  assign scl_fall = ~scl_f_i & scl_d;

  bus_st_e          st_q;
  logic [3:0]       bit_q;
  logic [7:0]       sh_q;
  logic [7:0]       tx_q;
  logic             rw_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_inc;

  assign idx_inc = (idx_q == '1) ? idx_q : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      idx_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_ev) begin
        st_q  <= ST_ADDR;
        bit_q <= '0;
        idx_q <= '0;
      end else if (stop_ev) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f_i};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (sh_q[7:1] == SLV_ADDR) begin
                rw_q <= sh_q[0];
                st_q <= ST_AACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q <= rd_data_i;
              st_q <= ST_RBYTE;
            end else begin
              st_q <= ST_WBYTE;
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f_i};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == 4'd8) begin
              st_q <= ST_WACK;
              if (idx_q >= IDX_W'(DUMMY_BYTES) &&
                  idx_q <  IDX_W'(DUMMY_BYTES + NBYTES)) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= 3'(idx_q - IDX_W'(DUMMY_BYTES));
                wr_data_o <= sh_q;
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            bit_q <= '0;
            idx_q <= idx_inc;
            st_q  <= ST_WBYTE;
          end
          ST_RBYTE: if (scl_fall) begin
            if (bit_q == 4'd7) begin
              bit_q <= '0;
              st_q  <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_f_i) st_q <= ST_IDLE;
              else         idx_q <= idx_inc;
            end else if (scl_fall) begin
              tx_q <= rd_data_i;
              st_q <= ST_RBYTE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // rd_idx_o follows the transfer index; the next byte is latched on the clock fall
  assign rd_idx_o = idx_q;
  assign sda_oe_o = (st_q == ST_AACK) || (st_q == ST_WACK) ||
                    ((st_q == ST_RBYTE) && !tx_q[7]);

  // R12
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_f_i);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  // R2
  write_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (!rw_q && wr_idx_o < 3'(NBYTES)));
  // R3
  no_drive_during_master_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK) |-> !sda_oe_o);
endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_fs_i,
  input  logic       strap_mult_i,
  input  logic       cpu_stop_pin_i,
  output logic       pci_stop_ctl_o,
  output logic       vch_48m_sel_o,
  output logic       spread_en_o,
  output logic [2:0] cpu_en_o,
  output logic [2:0] cpu_stop_ctl_o,
  output logic [6:0] pci_en_o,
  output logic [2:0] pcif_en_o,
  output logic [2:0] pcif_stop_ctl_o,
  output logic       usb_en_o,
  output logic       dot_en_o,
  output logic [5:0] clk66_en_o,
  output logic [1:0] usb_edge_o,
  output logic [1:0] dot_edge_o
);
  logic [1:0] line_raw, line_f;
  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    clkcfg_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(line_raw[g]), .clean_o(line_f[g])
    );
  end

  logic             wr_en;
  logic [2:0]       wr_idx;
  logic [7:0]       wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;
  logic [NBYTES*8-1:0] cfg;

  clkcfg_busctl #(.SLV_ADDR(SLV_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_f_i(line_f[1]), .sda_f_i(line_f[0]),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .rd_idx_o(rd_idx), .rd_data_i(rd_data)
  );

  clkcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .strap_fs_i(strap_fs_i), .strap_mult_i(strap_mult_i),
    .cpu_stop_pin_i(cpu_stop_pin_i), .cfg_o(cfg)
  );

  assign pci_stop_ctl_o  = cfg[3];
  assign vch_48m_sel_o   = cfg[5];
  assign spread_en_o     = cfg[7];
  assign cpu_en_o        = cfg[10:8];
  assign cpu_stop_ctl_o  = cfg[13:11];
  assign pci_en_o        = cfg[22:16];
  assign pcif_en_o       = cfg[26:24];
  assign pcif_stop_ctl_o = cfg[29:27];
  assign usb_en_o        = cfg[30];
  assign dot_en_o        = cfg[31];
  assign clk66_en_o      = cfg[37:32];
  assign usb_edge_o      = cfg[41:40];
  assign dot_edge_o      = cfg[43:42];

  logic unused_cfg;
  assign unused_cfg = ^{cfg[2:0], cfg[4], cfg[6], cfg[15:14], cfg[23],
                        cfg[39:38], cfg[55:44]};
endmodule

// File: tb/clkcfg_smb_slave_tb.sv
module clkcfg_smb_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
  logic sda_oe;
  logic scl_line, sda_line;
  logic [2:0] strap_fs = 3'b101;
  logic strap_mult = 1'b1;
  logic cpu_stop_pin = 1'b0;
  logic pci_stop_ctl, vch_sel, spread_en, usb_en, dot_en;
  logic [2:0] cpu_en, cpu_stop_ctl, pcif_en, pcif_stop_ctl;
  logic [6:0] pci_en;
  logic [5:0] clk66_en;
  logic [1:0] usb_edge, dot_edge;

  assign scl_line = scl_m | scl_gl;
  assign sda_line = sda_m & ~sda_oe & ~sda_gl;

  clkcfg_smb_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_fs_i(strap_fs), .strap_mult_i(strap_mult),
    .cpu_stop_pin_i(cpu_stop_pin), .pci_stop_ctl_o(pci_stop_ctl),
    .vch_48m_sel_o(vch_sel), .spread_en_o(spread_en), .cpu_en_o(cpu_en),
    .cpu_stop_ctl_o(cpu_stop_ctl), .pci_en_o(pci_en), .pcif_en_o(pcif_en),
    .pcif_stop_ctl_o(pcif_stop_ctl), .usb_en_o(usb_en), .dot_en_o(dot_en),
    .clk66_en_o(clk66_en), .usb_edge_o(usb_edge), .dot_edge_o(dot_edge)
  );

  int nvec = 0, nerr = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_q[$];

  // model state from the requirements: writable bits only
  logic [7:0] model [6];
  logic [7:0] wmask [6] = '{8'hA8, 8'h3F, 8'h7F, 8'hFF, 8'h3F, 8'h0F};
  logic [2:0] fs_cap = 3'b101;
  logic       mult_cap = 1'b1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic put_bit(logic b, bit glitch);
    sda_m = b; wt(Q/2);
    if (glitch) begin scl_gl = 1'b1; wt(1); scl_gl = 1'b0; end
    wt(Q/2);
    scl_m = 1'b1; wt(Q);
    if (glitch && b) begin sda_gl = 1'b1; wt(1); sda_gl = 1'b0; end
    wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic put_byte(logic [7:0] d, bit glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(logic master_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~master_ack, 1'b0);
  endtask

  // driver: full write transfer with model update
  task automatic do_write(logic [7:0] data [], int nbytes, bit glitch, string tag);
    logic ack;
    bus_start();
    put_byte(8'hD2, glitch, ack);
    chk({tag, " R1 addr ack"}, ack, 1);
    put_byte(8'hA5, glitch, ack); chk({tag, " R2 dummy0 ack"}, ack, 1);
    put_byte(8'h3C, glitch, ack); chk({tag, " R2 dummy1 ack"}, ack, 1);
    for (int i = 0; i < nbytes; i++) begin
      put_byte(data[i], glitch, ack);
      chk({tag, " R2 data ack"}, ack, 1);
      if (i < 6) model[i] = data[i] & wmask[i];
    end
    bus_stop();
  endtask

  function automatic logic [7:0] exp_byte(int i);
    case (i)
      0: return model[0] | {3'b0, cpu_stop_pin, 1'b0, fs_cap};
      1: return model[1] | {mult_cap, 7'b0};
      6: return 8'h07;
      default: return model[i];
    endcase
  endfunction

  // driver: read transfer, pushes expectations to the scoreboard
  task automatic do_read(int n, string tag);
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      if (i == 0)      exp_q.push_back(8'h08);
      else if (i <= 7) exp_q.push_back(exp_byte(i - 1));
      else             exp_q.push_back(8'h00);
      tag_q.push_back($sformatf("%s R3/R5-R8 read byte %0d", tag, i));
    end
    bus_start();
    put_byte(8'hD3, 1'b0, ack);
    chk({tag, " R1 read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      rx_q.push_back(d);
    end
    bus_stop();
  endtask

  task automatic check_outputs(string tag);
    chk({tag, " R5 byte0 outputs"}, {spread_en, 1'b0, vch_sel, 1'b0, pci_stop_ctl, 3'b0}, model[0]);
    chk({tag, " R6 byte1 outputs"}, {2'b0, cpu_stop_ctl, cpu_en}, model[1]);
    chk({tag, " R7 byte2 outputs"}, {1'b0, pci_en}, model[2]);
    chk({tag, " R7 byte3 outputs"}, {dot_en, usb_en, pcif_stop_ctl, pcif_en}, model[3]);
    chk({tag, " R7 byte4 outputs"}, {2'b0, clk66_en}, model[4]);
    chk({tag, " R8 byte5 outputs"}, {4'b0, dot_edge, usb_edge}, model[5]);
  endtask

  // monitor: compares read data against expectations as it arrives
  initial begin
    forever begin
      @(negedge clk);
      while (rx_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = rx_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, g, e);
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++; nvec++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    logic [7:0] d [];
    model = '{8'h08, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00};
    wt(5);
    chk("R12 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    strap_fs = 3'b010; strap_mult = 1'b0;
    // R4 reset state
    check_outputs("R4 reset");
    do_read(9, "R4");

    // R9: all-ones write, read-only and unused bits stay put
    d = new[7]; foreach (d[i]) d[i] = 8'hFF;
    do_write(d, 7, 1'b0, "R9 ones");
    wt(4);
    check_outputs("R9 ones");
    do_read(8, "R9");

    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    do_write(d, 7, 1'b0, "R2 zeros");
    wt(4);
    check_outputs("R2 zeros");

    // R1 wrong address: no ack, no change
    bus_start();
    put_byte(8'hD4, 1'b0, ack);
    chk("R1 foreign addr nack", ack, 0);
    put_byte(8'hFF, 1'b0, ack);
    put_byte(8'hFF, 1'b0, ack);
    put_byte(8'hFF, 1'b0, ack);
    bus_stop();
    wt(4);
    check_outputs("R1 foreign");

    // R10 early stop after two full bytes
    d = new[2]; d[0] = 8'hA0; d[1] = 8'h2A;
    do_write(d, 2, 1'b0, "R10 early");
    wt(4);
    check_outputs("R10 early");

    // R10 stop in the middle of byte 0
    bus_start();
    put_byte(8'hD2, 1'b0, ack);
    put_byte(8'h00, 1'b0, ack);
    put_byte(8'h00, 1'b0, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop();
    wt(4);
    check_outputs("R10 partial");

    // R5 live pin, R2 extra bytes beyond byte 6
    cpu_stop_pin = 1'b1;
    d = '{8'h28, 8'h15, 8'h55, 8'h6A, 8'h2D, 8'h09, 8'h33, 8'hFF, 8'hFF};
    do_write(d, 9, 1'b0, "R2 pattern");
    wt(4);
    check_outputs("R2 pattern");
    do_read(10, "R5 pin");

    // R11 glitches on both lines
    d = '{8'h80, 8'h3A, 8'h2B, 8'hD4, 8'h15, 8'h06, 8'h00};
    do_write(d, 7, 1'b1, "R11 glitch");
    wt(4);
    check_outputs("R11 glitch");
    do_read(3, "R11");

    wt(50);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule